// File: doc/BRIEF.md
# Burst Write Sequencer for Asynchronous Static Memory

This block turns a single write request from an on-chip master into a short burst of write beats toward an external asynchronous static memory or expansion device behind one chip select. The request carries a start address, a beat count, a size flag (word or halfword) and a stream of write data. The block accepts one data word per beat through a take strobe.

During the burst the block drives the chip select, the write strobe, the output enable, the address, the data, the size flag and a write-direction flag. Every beat can be lengthened in two ways that add together. The first is a wait-state count that is latched when the request is accepted. The second is an external ready line, which is sampled on the falling clock edge in the middle of each cycle.

Devices that latch data on the write strobe cannot take back-to-back strobes. When the strobe is enabled, the block therefore never runs a beat with zero wait states. A new request is refused while a burst is in flight, and a one-cycle done pulse marks the end of each burst.

Top module: `sram_burst_wr`

## Requirements
- R1: The beat count is the 3-bit `req_len`, clamped to the range 2 to 4 (0 and 1 give 2 beats, 5 to 7 give 4 beats). Exactly that many transfers occur, `mem_cs_n` stays low from the cycle after acceptance through the last transfer cycle, and it goes high in the following cycle.
- R2: If the wait count is 0, the strobe is disabled and ready is high, each beat lasts one clock, so an N-beat burst holds `mem_cs_n` low for exactly N cycles.
- R3: The wait count `w` is latched at acceptance. Each beat spends `w` cycles counting down before its transfer cycle, so with ready high a burst lasts N*(w+1) cycles.
- R4: `ext_rdy` is sampled on the falling clock edge of each cycle. If the countdown has expired and the sample is low, the transfer is postponed by one cycle and ready is sampled again. These stall cycles add to the wait count.
- R5: If `cfg_strobe_en` is 1 at acceptance and `cfg_wait` is 0, the block uses a wait count of 1.
- R6: `mem_we_n` is low only in the transfer cycle of a beat, and only when the strobe is enabled. That gives exactly one low pulse per beat and never two low cycles in a row. When the strobe is disabled, `mem_we_n` stays high.
- R7: Beat k uses the address `req_addr + k*4` for word bursts (`req_half`=0) or `req_addr + k*2` for halfword bursts (`req_half`=1). `mem_half` equals `req_half`.
- R8: `data_take` is high in the acceptance cycle and in each transfer cycle except the last. The value of `wr_data` in that cycle is the data of the next beat.
- R9: `mem_addr`, `mem_data`, `mem_half` and `mem_write` keep their last burst values after the burst until the next request is accepted. `mem_write` becomes 1 at the first acceptance.
- R10: `mem_oe_n` is high at all times.
- R11: `done` is high for exactly one cycle, the first cycle in which `mem_cs_n` is high again after a burst.
- R12: `busy` is high throughout a burst. A `req_valid` that arrives while `busy` is high is ignored: it changes neither the burst in progress nor the outputs after it.
- R13: After reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are high, `busy`, `done`, `data_take` and `mem_write` are low, and `mem_addr` and `mem_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | WAIT_W | Wait states per beat, latched at acceptance |
| cfg_strobe_en | input | 1 | Target uses the write strobe, latched at acceptance |
| req_valid | input | 1 | Burst request, accepted when idle |
| req_addr | input | ADDR_W | Start address |
| req_len | input | 3 | Requested beat count (clamped to 2..4) |
| req_half | input | 1 | 1 selects halfword beats, 0 selects word beats |
| wr_data | input | DATA_W | Write data, taken when data_take is high |
| data_take | output | 1 | wr_data is consumed this cycle |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| ext_rdy | input | 1 | External ready, sampled on the falling edge |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low (held high) |
| mem_addr | output | ADDR_W | Beat address |
| mem_data | output | DATA_W | Beat data |
| mem_half | output | 1 | Halfword size flag |
| mem_write | output | 1 | Write-direction flag |

## Verification
Every cycle, the assertions check the following: the strobe never falls outside the chip select and never stays low two cycles in a row, the wait countdown steps down by one, a low ready sample holds the transfer, a strobe-enabled start never loads a zero count, the beat counter stays within four, and the done pulse sits right after the select is released. Only the bench's scenarios can show the rest. That covers the exact length of each beat under random ready patterns, the address stride and data order for each size, the clamping of out-of-range lengths, and that a request arriving mid-burst leaves no trace.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } sbw_state_e;

  localparam int unsigned LEN_W     = 3;
  localparam int unsigned MIN_BEATS = 2;
  localparam int unsigned MAX_BEATS = 4;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] res;
    res = len;
    if (len < LEN_W'(MIN_BEATS)) res = LEN_W'(MIN_BEATS);
    else if (len > LEN_W'(MAX_BEATS)) res = LEN_W'(MAX_BEATS);
    return res;
  endfunction
endpackage

// File: rtl/sbw_rdy_sample.sv
module sbw_rdy_sample #(
  parameter bit FALL_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rdy,
  output logic rdy_q
);
  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= ext_rdy;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= ext_rdy;
      end
    end
  endgenerate
endmodule

// File: rtl/sbw_wait_timer.sv
module sbw_wait_timer #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_strobe_en,
  input  logic              run,
  input  logic              reload,
  input  logic              rdy_q,
  output logic              xfer,
  output logic              strobe_q
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [WAIT_W-1:0] reload_q, reload_d;
  logic [WAIT_W-1:0] start_val;
  logic              strobe_d;

  always_comb begin
    start_val = cfg_wait;
    if (cfg_strobe_en && (cfg_wait == '0)) start_val = WAIT_W'(1);
  end

  assign xfer = run && (cnt_q == '0) && rdy_q;

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    strobe_d = strobe_q;
    if (start) begin
      cnt_d    = start_val;
      reload_d = start_val;
      strobe_d = cfg_strobe_en;
    end else if (reload) begin
      cnt_d = reload_q;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - WAIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      strobe_q <= strobe_d;
    end
  end

  // R3
  wait_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - WAIT_W'(1)));

  // R4
  rdy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && (cnt_q == '0) && !rdy_q) |=> (cnt_q == '0));

  // R5
  strobe_min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_strobe_en) |=> (cnt_q != '0));
endmodule

// File: rtl/sbw_beat_seq.sv
module sbw_beat_seq
  import sbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              start_half,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              advance,
  output logic              last,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              half_q,
  output logic              write_q
);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);

  logic [LEN_W-1:0]  beats_q, beats_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              half_d, write_d;
  logic [ADDR_W-1:0] step;

  assign last = (beats_q == LEN_W'(1));
  assign step = half_q ? STEP_HALF : STEP_WORD;

  always_comb begin
    beats_d = beats_q;
    addr_d  = addr_q;
    data_d  = data_q;
    half_d  = half_q;
    write_d = write_q;
    if (start) begin
      beats_d = clamp_len(start_len);
      addr_d  = start_addr;
      data_d  = wr_data;
      half_d  = start_half;
      write_d = 1'b1;
    end else if (advance) begin
      if (last) begin
        beats_d = '0;
      end else begin
        beats_d = beats_q - LEN_W'(1);
        addr_d  = addr_q + step;
        data_d  = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      half_q  <= 1'b0;
      write_q <= 1'b0;
    end else begin
      beats_q <= beats_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      half_q  <= half_d;
      write_q <= write_d;
    end
  end

  // R1
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beats_q <= LEN_W'(MAX_BEATS));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !advance) |=> ($stable(addr_q) && $stable(data_q) && $stable(half_q)));
endmodule

// File: rtl/sram_burst_wr.sv
module sram_burst_wr
  import sbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_strobe_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_len,
  input  logic              req_half,
  input  logic [DATA_W-1:0] wr_data,
  output logic              data_take,
  output logic              busy,
  output logic              done,
  input  logic              ext_rdy,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_half,
  output logic              mem_write
);
  sbw_state_e state_q, state_d;
  logic done_d;
  logic accept, in_beat, xfer, last, reload, rdy_q, strobe_q;

  assign in_beat = (state_q == ST_BEAT);
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign reload  = xfer && !last;

  sbw_rdy_sample #(.FALL_EDGE(1'b1)) rdy_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_rdy (ext_rdy),
    .rdy_q   (rdy_q)
  );

  sbw_wait_timer #(.WAIT_W(WAIT_W)) timer_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .cfg_wait      (cfg_wait),
    .cfg_strobe_en (cfg_strobe_en),
    .run           (in_beat),
    .reload        (reload),
    .rdy_q         (rdy_q),
    .xfer          (xfer),
    .strobe_q      (strobe_q)
  );

  sbw_beat_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (req_addr),
    .start_len  (req_len),
    .start_half (req_half),
    .wr_data    (wr_data),
    .advance    (xfer),
    .last       (last),
    .addr_q     (mem_addr),
    .data_q     (mem_data),
    .half_q     (mem_half),
    .write_q    (mem_write)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_BEAT;
      ST_BEAT: if (xfer && last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign busy      = in_beat;
  assign data_take = accept || reload;
  assign mem_cs_n  = !in_beat;
  assign mem_we_n  = !(strobe_q && xfer);
  assign mem_oe_n  = 1'b1;

  // R6
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  // R6
  we_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> mem_we_n);

  // R11
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n && $past(!mem_cs_n)));

  // R12
  busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer) |-> !data_take);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n && $past(mem_cs_n)) |-> $stable(mem_addr));
endmodule

// File: tb/sram_burst_wr_tb_top.sv
module sram_burst_wr_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WAIT_W = 4;
  localparam int WDOG = 100000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [WAIT_W-1:0] cfg_wait;
  logic              cfg_strobe_en;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [2:0]        req_len;
  logic              req_half;
  logic [DATA_W-1:0] wr_data;
  logic              data_take, busy, done, ext_rdy;
  logic              mem_cs_n, mem_we_n, mem_oe_n, mem_half, mem_write;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sram_burst_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_strobe_en(cfg_strobe_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_half(req_half),
    .wr_data(wr_data), .data_take(data_take), .busy(busy), .done(done), .ext_rdy(ext_rdy),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_half(mem_half), .mem_write(mem_write)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_beats(input logic [2:0] len);
    if (len < 3'd2) return 2;
    if (len > 3'd4) return 4;
    return int'(len);
  endfunction

  function automatic int exp_wait(input logic [WAIT_W-1:0] w, input logic strobe);
    if (strobe && w == '0) return 1;
    return int'(w);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: cycles=%0d expected below %0d", cycles, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_burst(input logic [ADDR_W-1:0] addr, input logic [2:0] len,
                           input logic half, input logic [WAIT_W-1:0] w,
                           input logic strobe, input int rdy_pct, input bit poke);
    logic [DATA_W-1:0] pat [4];
    int nb, effw, beat, cnt, k, len_cycles, idx;
    logic [ADDR_W-1:0] step;
    logic rdy, xf;
    nb   = exp_beats(len);
    effw = exp_wait(w, strobe);
    step = half ? ADDR_W'(2) : ADDR_W'(4);
    for (int i = 0; i < 4; i++) pat[i] = $urandom;
    @(posedge clk); #2;
    cfg_wait = w; cfg_strobe_en = strobe;
    req_valid = 1'b1; req_addr = addr; req_len = len; req_half = half;
    wr_data = pat[0]; ext_rdy = 1'b1;
    #6;
    chk("R12 idle before accept busy", 32'(busy), 32'd0);
    chk("R8 take at accept", 32'(data_take), 32'd1);
    k = 1; beat = 0; cnt = effw; len_cycles = 0; idx = 0;
    while (beat < nb) begin
      @(posedge clk); #2;
      rdy = (($urandom % 100) < 32'(rdy_pct));
      ext_rdy = rdy;
      wr_data = pat[(k < 4) ? k : 3];
      if (poke && idx == 1) begin
        req_valid = 1'b1; req_addr = ~addr; req_len = 3'd4; req_half = ~half;
      end else begin
        req_valid = 1'b0;
      end
      idx++;
      #6;
      len_cycles++;
      xf = (cnt == 0) && rdy;
      chk("R1 cs low during burst", 32'(mem_cs_n), 32'd0);
      chk("R12 busy during burst", 32'(busy), 32'd1);
      chk("R10 oe high", 32'(mem_oe_n), 32'd1);
      chk("R6 we strobe", 32'(mem_we_n), 32'(!(strobe && xf)));
      chk("R8 take", 32'(data_take), 32'(xf && (beat < nb - 1)));
      if (xf) begin
        chk("R7 beat address", mem_addr, addr + ADDR_W'(beat) * step);
        chk("R7 size flag", 32'(mem_half), 32'(half));
        chk("R8 beat data", mem_data, pat[beat]);
        chk("R9 write flag", 32'(mem_write), 32'd1);
        beat++;
        if (data_take) k++;
        cnt = effw;
      end else if (cnt > 0) begin
        cnt--;
      end
      if (len_cycles > 200) break;
    end
    if (rdy_pct >= 100)
      chk("R2 R3 R5 burst length", 32'(len_cycles), 32'(nb * (effw + 1)));
    @(posedge clk); #2;
    req_valid = 1'b0; ext_rdy = 1'b1;
    #6;
    chk("R1 cs released", 32'(mem_cs_n), 32'd1);
    chk("R11 done pulse", 32'(done), 32'd1);
    chk("R12 busy cleared", 32'(busy), 32'd0);
    @(posedge clk); #8;
    chk("R11 done one cycle", 32'(done), 32'd0);
    chk("R12 no extra burst", 32'(mem_cs_n), 32'd1);
    chk("R9 address held", mem_addr, addr + ADDR_W'(nb - 1) * step);
    chk("R9 data held", mem_data, pat[nb - 1]);
    chk("R9 size held", 32'(mem_half), 32'(half));
    chk("R6 we idle", 32'(mem_we_n), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_wait = '0; cfg_strobe_en = 1'b0; req_valid = 1'b0;
    req_addr = '0; req_len = 3'd2; req_half = 1'b0; wr_data = '0; ext_rdy = 1'b1;
    repeat (3) @(posedge clk);
    #8;
    chk("R13 cs reset", 32'(mem_cs_n), 32'd1);
    chk("R13 we reset", 32'(mem_we_n), 32'd1);
    chk("R13 oe reset", 32'(mem_oe_n), 32'd1);
    chk("R13 busy reset", 32'(busy), 32'd0);
    chk("R13 done reset", 32'(done), 32'd0);
    chk("R13 take reset", 32'(data_take), 32'd0);
    chk("R13 write reset", 32'(mem_write), 32'd0);
    chk("R13 addr reset", mem_addr, 32'd0);
    chk("R13 data reset", mem_data, 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    // R2: minimum-wait four-beat burst, strobe disabled
    run_burst(32'h0000_1000, 3'd4, 1'b0, 4'd0, 1'b0, 100, 1'b0);
    // R1: out-of-range lengths clamp
    run_burst(32'h0000_2000, 3'd0, 1'b1, 4'd0, 1'b0, 100, 1'b0);
    run_burst(32'h0000_3000, 3'd7, 1'b1, 4'd2, 1'b0, 100, 1'b0);
    run_burst(32'h0000_3800, 3'd1, 1'b0, 4'd1, 1'b1, 100, 1'b0);
    // R5: strobe enabled with zero wait forces one wait state
    run_burst(32'h0000_4000, 3'd4, 1'b0, 4'd0, 1'b1, 100, 1'b0);
    // R3: longer wait count
    run_burst(32'hFFFF_FFF8, 3'd3, 1'b0, 4'd5, 1'b1, 100, 1'b0);
    // R4: ready stalls, R12: request while busy
    run_burst(32'h0000_5000, 3'd4, 1'b1, 4'd0, 1'b0, 40, 1'b1);
    run_burst(32'h0000_6000, 3'd3, 1'b0, 4'd2, 1'b1, 50, 1'b1);
    for (int n = 0; n < 40; n++) begin
      run_burst($urandom, 3'($urandom), 1'($urandom), WAIT_W'($urandom % 4),
                1'($urandom), 30 + int'($urandom % 71), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule